// File: doc/BRIEF.md
# Streaming Video Timing Generator

This block takes pixels from a valid/ready stream and emits them as timed display video. Each output cycle carries a horizontal sync, a vertical sync, a data-enable and one pixel word. Incoming words carry a start-of-frame flag. They wait in a small input queue until the timing engine draws them out, one word per active pixel.

Software programs a few independent video modes through a register port with a write strobe and a combinational read. Each mode holds an active width and an active height. It also holds a front porch, a sync width and a back porch for each direction, plus a validity flag and two sync polarity flags. At every frame start the engine latches the lowest-numbered valid mode and reports its index.

If the queue runs dry while a pixel is due, the block does not emit stale data. It blanks the outputs and records a sticky underflow flag. It then drops input until the next start-of-frame word and starts a fresh frame from its first active line.

Top module: `vid_stream_timer`

## Requirements
- R1: Every line lasts hact+hfp+hsw+hbp cycles. Data-enable stays low for hfp+hsw+hbp consecutive cycles between lines. Horizontal sync is active for exactly hsw cycles, starting hact+hfp cycles after line start. Example: 40+1+216 gives a blanking gap of 257 cycles.
- R2: Mode m sits at word addresses 16*(m+1)+k. The k values are: 0 = flags, 1 = hact, 2 = hfp, 3 = hsw, 4 = hbp, 5 = vact, 6 = vfp, 7 = vsw, 8 = vbp. A write to k = 1..8 is ignored while that mode's valid flag is set, and takes effect once the flag is cleared. All words read back at the same addresses.
- R3: At each frame start the engine latches the lowest-numbered mode whose valid flag is set. The current-mode register at address 1 reads the latched index, and reads 0 when no mode has been latched.
- R4: After a start-of-frame word reaches the queue head, output stays idle until the queue level is at least the start threshold held at address 2.
- R5: Data-enable is high only for active pixels, hact*vact per frame. One queued word is emitted per enabled cycle, in arrival order.
- R6: Flags bit 1 set makes horizontal sync active-high, and bit 2 does the same for vertical sync. A cleared bit makes that sync active-low. Bit 0 is the valid flag.
- R7: Status bit 0 at address 0 is set when a pixel is due and the queue is empty. It stays set until 1 is written to bit 0. Writing 0 leaves it set.
- R8: After starvation the outputs blank and the queued input is discarded up to the next start-of-frame word. Output then restarts at the first active line of a new frame.
- R9: Size fields are 12 bits wide, so an 800x480 active region with 257-cycle horizontal blanking is programmable and runs.
- R10: A frame lasts vact+vfp+vsw+vbp lines. Vertical sync is active for vsw whole lines, starting vact+vfp lines after frame start.
- R11: After reset: data-enable is low, both syncs are high, status reads 0, the current mode reads 0, and the stream input is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input word valid |
| s_ready | output | 1 | Queue can accept a word |
| s_sof | input | 1 | Word is the first pixel of a frame |
| s_data | input | PIX_W | Input pixel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register word address |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational) |
| vid_hs | output | 1 | Horizontal sync |
| vid_vs | output | 1 | Vertical sync |
| vid_de | output | 1 | Data-enable |
| vid_data | output | PIX_W | Output pixel |

## Verification
The hardest state to reach is a starved queue partway through a frame, followed by a stream that does not start on a frame boundary. The bench caps the number of words it supplies at one frame plus two pixels, so the engine runs dry on the third pixel of the second frame. It then lifts the cap, which makes ten mid-frame words arrive ahead of the next start-of-frame word. The bench checks that these ten are dropped and that the restart lands on the first active line.

// File: rtl/vto_pkg.sv
package vto_pkg;
  localparam int CW = 12;
  localparam int TW = CW + 2;

  typedef struct packed {
    logic          valid;
    logic          hpol;
    logic          vpol;
    logic [CW-1:0] hact;
    logic [CW-1:0] hfp;
    logic [CW-1:0] hsw;
    logic [CW-1:0] hbp;
    logic [CW-1:0] vact;
    logic [CW-1:0] vfp;
    logic [CW-1:0] vsw;
    logic [CW-1:0] vbp;
  } mode_t;

  function automatic logic [TW-1:0] gap_len(input logic [CW-1:0] fp, input logic [CW-1:0] sw,
                                            input logic [CW-1:0] bp);
    return TW'(fp) + TW'(sw) + TW'(bp);
  endfunction

  function automatic logic [TW-1:0] period_len(input logic [CW-1:0] act, input logic [CW-1:0] fp,
                                               input logic [CW-1:0] sw, input logic [CW-1:0] bp);
    return TW'(act) + gap_len(fp, sw, bp);
  endfunction

  function automatic logic in_window(input logic [TW-1:0] pos, input logic [CW-1:0] act,
                                     input logic [CW-1:0] fp, input logic [CW-1:0] sw);
    logic [TW-1:0] lo;
    lo = TW'(act) + TW'(fp);
    return (pos >= lo) && (pos < lo + TW'(sw));
  endfunction
endpackage

// File: rtl/vto_fifo.sv
module vto_fifo #(
  parameter int W     = 25,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic [AW:0]  level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = level == (AW+1)'(DEPTH);
  assign empty   = level == '0;
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      level <= level + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

  // the engine must detect starvation itself and never draw from an empty queue
  assert_no_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/vto_regs.sv
module vto_regs
  import vto_pkg::*;
#(
  parameter int NUM_MODES = 2,
  parameter int RAW       = 6,
  parameter int REG_W     = 16,
  parameter int LW        = 5,
  localparam int IW       = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [RAW-1:0]   addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             uflow_evt,
  input  logic [IW-1:0]    cur_idx,
  output logic [LW-1:0]    thr,
  output mode_t            sel_mode,
  output logic             sel_any,
  output logic [IW-1:0]    sel_idx
);
  mode_t [NUM_MODES-1:0] mode_q;
  logic                  uflow_q;
  logic                  clr_req;
  logic                  unused_hi;

  assign unused_hi = ^wdata[REG_W-1:CW];
  assign clr_req   = we && addr == RAW'(0) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uflow_q <= 1'b0;
      thr     <= LW'(1);
    end else begin
      if (uflow_evt)    uflow_q <= 1'b1;
      else if (clr_req) uflow_q <= 1'b0;
      if (we && addr == RAW'(2)) thr <= wdata[LW-1:0];
    end
  end

  assert_sticky_uflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(uflow_q) && !$past(clr_req)) |-> uflow_q);

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    mode_t q;
    logic  pg, locked_wr;
    assign pg        = addr[RAW-1:4] == (RAW-4)'(m + 1);
    assign locked_wr = we && pg && addr[3:0] != 4'd0 && addr[3:0] < 4'd9 && q.valid;
    assign mode_q[m] = q;

    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (we && pg) begin
        case (addr[3:0])
          4'd0: begin q.valid <= wdata[0]; q.hpol <= wdata[1]; q.vpol <= wdata[2]; end
          4'd1: if (!q.valid) q.hact <= wdata[CW-1:0];
          4'd2: if (!q.valid) q.hfp  <= wdata[CW-1:0];
          4'd3: if (!q.valid) q.hsw  <= wdata[CW-1:0];
          4'd4: if (!q.valid) q.hbp  <= wdata[CW-1:0];
          4'd5: if (!q.valid) q.vact <= wdata[CW-1:0];
          4'd6: if (!q.valid) q.vfp  <= wdata[CW-1:0];
          4'd7: if (!q.valid) q.vsw  <= wdata[CW-1:0];
          4'd8: if (!q.valid) q.vbp  <= wdata[CW-1:0];
          default: ;
        endcase
      end
    end

    assert_param_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      locked_wr |=> q == $past(q));
  end

  always_comb begin
    sel_any = 1'b0;
    sel_idx = '0;
    for (int m = NUM_MODES - 1; m >= 0; m--) begin
      if (mode_q[m].valid) begin
        sel_any = 1'b1;
        sel_idx = IW'(m);
      end
    end
  end
  assign sel_mode = mode_q[sel_idx];

  always_comb begin
    rdata = '0;
    if (addr == RAW'(0)) rdata[0] = uflow_q;
    if (addr == RAW'(1)) rdata = REG_W'(cur_idx);
    if (addr == RAW'(2)) rdata = REG_W'(thr);
    for (int m = 0; m < NUM_MODES; m++) begin
      if (addr[RAW-1:4] == (RAW-4)'(m + 1)) begin
        case (addr[3:0])
          4'd0: rdata = REG_W'({mode_q[m].vpol, mode_q[m].hpol, mode_q[m].valid});
          4'd1: rdata = REG_W'(mode_q[m].hact);
          4'd2: rdata = REG_W'(mode_q[m].hfp);
          4'd3: rdata = REG_W'(mode_q[m].hsw);
          4'd4: rdata = REG_W'(mode_q[m].hbp);
          4'd5: rdata = REG_W'(mode_q[m].vact);
          4'd6: rdata = REG_W'(mode_q[m].vfp);
          4'd7: rdata = REG_W'(mode_q[m].vsw);
          4'd8: rdata = REG_W'(mode_q[m].vbp);
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vto_timing.sv
module vto_timing
  import vto_pkg::*;
#(
  parameter int PIX_W = 24,
  parameter int LW    = 5,
  parameter int IW    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mode_t            sel_mode,
  input  logic             sel_any,
  input  logic [IW-1:0]    sel_idx,
  input  logic [LW-1:0]    thr,
  input  logic [LW-1:0]    level,
  input  logic             empty,
  input  logic             head_sof,
  input  logic [PIX_W-1:0] head_data,
  output logic             pop,
  output logic             uflow_evt,
  output logic [IW-1:0]    cur_idx,
  output logic             vid_hs,
  output logic             vid_vs,
  output logic             vid_de,
  output logic [PIX_W-1:0] vid_data
);
  typedef enum logic [1:0] {ST_SEEK, ST_FILL, ST_RUN} st_t;

  st_t           st;
  mode_t         cm;
  logic [TW-1:0] hc, vc;
  logic          h_last, v_last, act, hs_on, vs_on, starve;
  logic          unused_flags;

  assign unused_flags = cm.valid ^ sel_mode.valid;
  assign h_last = hc == period_len(cm.hact, cm.hfp, cm.hsw, cm.hbp) - TW'(1);
  assign v_last = vc == period_len(cm.vact, cm.vfp, cm.vsw, cm.vbp) - TW'(1);
  assign act    = (hc < TW'(cm.hact)) && (vc < TW'(cm.vact));
  assign hs_on  = in_window(hc, cm.hact, cm.hfp, cm.hsw);
  assign vs_on  = in_window(vc, cm.vact, cm.vfp, cm.vsw);
  assign starve = (st == ST_RUN) && act && empty;
  assign uflow_evt = starve;
  assign pop = ((st == ST_SEEK) && !empty && !head_sof) || ((st == ST_RUN) && act && !empty);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_SEEK; cm <= '0; hc <= '0; vc <= '0; cur_idx <= '0;
      vid_de <= 1'b0; vid_data <= '0; vid_hs <= 1'b1; vid_vs <= 1'b1;
    end else begin
      case (st)
        ST_SEEK: begin
          vid_de <= 1'b0; vid_hs <= ~cm.hpol; vid_vs <= ~cm.vpol;
          if (!empty && head_sof) st <= ST_FILL;
        end
        ST_FILL: begin
          vid_de <= 1'b0; vid_hs <= ~cm.hpol; vid_vs <= ~cm.vpol;
          if (sel_any && level >= thr) begin
            cm <= sel_mode; cur_idx <= sel_idx; hc <= '0; vc <= '0; st <= ST_RUN;
          end
        end
        default: begin
          if (starve) begin
            st <= ST_SEEK;
            vid_de <= 1'b0; vid_hs <= ~cm.hpol; vid_vs <= ~cm.vpol;
          end else begin
            vid_de   <= act;
            vid_data <= act ? head_data : '0;
            vid_hs   <= ~(hs_on ^ cm.hpol);
            vid_vs   <= ~(vs_on ^ cm.vpol);
            if (h_last) begin
              hc <= '0;
              if (v_last) begin
                vc <= '0;
                if (sel_any) begin cm <= sel_mode; cur_idx <= sel_idx; end
                else st <= ST_SEEK;
              end else vc <= vc + TW'(1);
            end else hc <= hc + TW'(1);
          end
        end
      endcase
    end
  end

  assert_start_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && $past(st) == ST_FILL) |-> ($past(level) >= $past(thr)));
  assert_blank_after_starve_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(starve) |-> !vid_de);
  assert_de_only_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vid_de |-> $past(st) == ST_RUN);
endmodule

// File: rtl/vid_stream_timer.sv
module vid_stream_timer
  import vto_pkg::*;
#(
  parameter int PIX_W      = 24,
  parameter int FIFO_DEPTH = 16,
  parameter int NUM_MODES  = 2,
  parameter int REG_W      = 16,
  localparam int RAW       = $clog2(16 * (NUM_MODES + 1)),
  localparam int LW        = $clog2(FIFO_DEPTH) + 1,
  localparam int IW        = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             s_sof,
  input  logic [PIX_W-1:0] s_data,
  input  logic             reg_we,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             vid_hs,
  output logic             vid_vs,
  output logic             vid_de,
  output logic [PIX_W-1:0] vid_data
);
  logic             full, empty, pop, uflow_evt, sel_any;
  logic [PIX_W:0]   head;
  logic [LW-1:0]    level, thr;
  logic [IW-1:0]    sel_idx, cur_idx;
  mode_t            sel_mode;

  assign s_ready = !full;

  vto_fifo #(.W(PIX_W + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(s_valid), .din({s_sof, s_data}), .full(full),
    .pop(pop), .dout(head), .empty(empty), .level(level)
  );

  vto_regs #(.NUM_MODES(NUM_MODES), .RAW(RAW), .REG_W(REG_W), .LW(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .uflow_evt(uflow_evt), .cur_idx(cur_idx), .thr(thr),
    .sel_mode(sel_mode), .sel_any(sel_any), .sel_idx(sel_idx)
  );

  vto_timing #(.PIX_W(PIX_W), .LW(LW), .IW(IW)) u_timing (
    .clk(clk), .rst_n(rst_n), .sel_mode(sel_mode), .sel_any(sel_any), .sel_idx(sel_idx),
    .thr(thr), .level(level), .empty(empty), .head_sof(head[PIX_W]),
    .head_data(head[PIX_W-1:0]), .pop(pop), .uflow_evt(uflow_evt), .cur_idx(cur_idx),
    .vid_hs(vid_hs), .vid_vs(vid_vs), .vid_de(vid_de), .vid_data(vid_data)
  );
endmodule

// File: tb/sim_vid_stream_timer.sv
module sim_vid_stream_timer;
  localparam int PERIOD = 10;
  localparam int PW     = 24;
  localparam int RAW    = 6;
  // hact hfp hsw hbp vact vfp vsw vbp hpol vpol | expected line period, expected gap
  localparam int NROW = 4;
  localparam int TBL [NROW][12] = '{
    '{  4,  2, 1,   3, 3, 1, 2, 1, 1, 1,   10,   6},
    '{  6,  1, 3,   2, 2, 2, 1, 1, 0, 1,   12,   6},
    '{  5,  3, 2,   1, 4, 1, 1, 2, 1, 0,   11,   6},
    '{800, 40, 1, 216, 2, 1, 1, 1, 1, 1, 1057, 257}
  };

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_sof = 0, reg_we = 0;
  logic [PW-1:0] s_data = '0;
  logic [RAW-1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic s_ready, vid_hs, vid_vs, vid_de;
  logic [15:0] reg_rdata;
  logic [PW-1:0] vid_data;

  int total = 0, fails = 0;
  int pix_idx = 0, feed_limit = 0, frame_px = 1;
  bit feed_on = 0, fire = 0, done = 0;

  always #(PERIOD/2) clk = ~clk;

  vid_stream_timer u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_sof(s_sof),
    .s_data(s_data), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vid_hs(vid_hs), .vid_vs(vid_vs), .vid_de(vid_de),
    .vid_data(vid_data)
  );

  // stream source: word n carries value n, flagged at every frame boundary
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        pix_idx = 0; fire = 0;
      end else if (fire) pix_idx++;
      s_valid = feed_on && rst_n && (pix_idx < feed_limit);
      s_data  = pix_idx[PW-1:0];
      s_sof   = (pix_idx % frame_px) == 0;
      fire    = s_valid && s_ready;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_addr = RAW'(a); reg_wdata = 16'(d); reg_we = 1;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = RAW'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic do_reset();
    feed_on = 0; feed_limit = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic prog(input int m, input int r);
    for (int k = 1; k <= 8; k++) wr(16 * (m + 1) + k, TBL[r][k-1]);
    wr(16 * (m + 1), 1 | (TBL[r][8] << 1) | (TBL[r][9] << 2));
  endtask

  task automatic wait_de(input int limit, output bit seen);
    seen = 0;
    for (int i = 0; i < limit && !seen; i++) begin
      @(negedge clk);
      if (vid_de) seen = 1;
    end
  endtask

  task automatic run_row(input int r);
    int htot, vtot, win, de_n, hs_n, vs_n, bad, line2, fall, lowrun, hs_st, hs_w, first;
    bit pde, seen, have;
    logic [PW-1:0] prev;
    htot = TBL[r][0] + TBL[r][1] + TBL[r][2] + TBL[r][3];
    vtot = TBL[r][4] + TBL[r][5] + TBL[r][6] + TBL[r][7];
    win = 2 * htot * vtot;
    do_reset();
    prog(0, r);
    wr(2, 4);
    frame_px = TBL[r][0] * TBL[r][4];
    feed_limit = 1 << 30; feed_on = 1;
    wait_de(4000, seen);
    chk($sformatf("R4 row%0d output started", r), int'(seen), 1);
    first = int'(vid_data);
    de_n = 0; hs_n = 0; vs_n = 0; bad = 0; line2 = -1; fall = -1; lowrun = -1;
    hs_st = -1; hs_w = -1; pde = 0; have = 0; prev = '0;
    for (int i = 0; i < win; i++) begin
      bit de, hsa, vsa;
      if (i > 0) @(negedge clk);
      de = vid_de; hsa = (vid_hs == TBL[r][8][0]); vsa = (vid_vs == TBL[r][9][0]);
      de_n += int'(de); hs_n += int'(hsa); vs_n += int'(vsa);
      if (de) begin
        if (have && vid_data != prev + 1'b1) bad++;
        prev = vid_data; have = 1;
      end
      if (de && !pde && i > 0 && line2 < 0) line2 = i;
      if (!de && pde && fall < 0) fall = i;
      if (de && !pde && fall >= 0 && lowrun < 0) lowrun = i - fall;
      if (hsa && hs_st < 0) hs_st = i;
      if (!hsa && hs_st >= 0 && hs_w < 0) hs_w = i - hs_st;
      pde = de;
    end
    chk($sformatf("R1 R9 row%0d line period", r), line2, TBL[r][10]);
    chk($sformatf("R1 R9 row%0d enable-low gap", r), lowrun, TBL[r][11]);
    chk($sformatf("R1 R6 row%0d hsync width", r), hs_w, TBL[r][2]);
    chk($sformatf("R1 R6 row%0d hsync cycles", r), hs_n, 2 * vtot * TBL[r][2]);
    chk($sformatf("R10 R6 row%0d vsync cycles", r), vs_n, 2 * htot * TBL[r][6]);
    chk($sformatf("R5 row%0d enabled cycles", r), de_n, 2 * TBL[r][0] * TBL[r][4]);
    chk($sformatf("R5 row%0d pixel order breaks", r), bad, 0);
    chk($sformatf("R5 row%0d first pixel", r), first, 0);
  endtask

  initial begin
    int v, cnt;
    bit seen;
    do_reset();
    // R11 reset state
    @(negedge clk);
    chk("R11 de low", int'(vid_de), 0);
    chk("R11 hsync high", int'(vid_hs), 1);
    chk("R11 vsync high", int'(vid_vs), 1);
    chk("R11 ready", int'(s_ready), 1);
    rd(0, v); chk("R11 status", v, 0);
    rd(1, v); chk("R11 R3 current mode", v, 0);

    for (int r = 0; r < NROW; r++) run_row(r);

    // R4 start threshold
    do_reset();
    prog(0, 0); wr(2, 5);
    frame_px = 12; feed_limit = 4; feed_on = 1;
    cnt = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); cnt += int'(vid_de); end
    chk("R4 idle below threshold", cnt, 0);
    feed_limit = 5;
    wait_de(30, seen);
    chk("R4 starts at threshold", int'(seen), 1);
    chk("R4 first word", int'(vid_data), 0);

    // R7 R8 starvation and resync
    do_reset();
    prog(0, 0); wr(2, 4);
    frame_px = 12; feed_limit = 14; feed_on = 1;
    v = 0;
    for (int i = 0; i < 100 && v == 0; i++) begin repeat (4) @(negedge clk); rd(0, v); end
    chk("R7 underflow set", v, 1);
    repeat (20) @(negedge clk);
    rd(0, v); chk("R7 underflow sticky", v, 1);
    wr(0, 0); rd(0, v); chk("R7 write 0 keeps flag", v, 1);
    wr(0, 1); rd(0, v); chk("R7 write 1 clears flag", v, 0);
    feed_limit = 1 << 30;
    wait_de(200, seen);
    chk("R8 restart seen", int'(seen), 1);
    chk("R8 first word after resync", int'(vid_data), 24);
    cnt = 0;
    for (int i = 0; i < 100 && vid_vs != 1'b1; i++) begin
      cnt += int'(vid_de);
      @(negedge clk);
    end
    chk("R8 restart at first active line", cnt, 12);

    // R3 selection, R2 lock, R9 field size
    do_reset();
    frame_px = 12;
    prog(1, 0); wr(2, 4);
    rd(1, v); chk("R3 no mode latched", v, 0);
    feed_limit = 1 << 30; feed_on = 1;
    wait_de(200, seen);
    rd(1, v); chk("R3 only mode 1 valid", v, 1);
    prog(0, 0);
    repeat (160) @(negedge clk);
    rd(1, v); chk("R3 lowest valid wins", v, 0);
    wr(17, 9); rd(17, v); chk("R2 write ignored while valid", v, 4);
    wr(16, 6); wr(17, 9); rd(17, v); chk("R2 write taken after invalidate", v, 9);
    rd(16, v); chk("R2 R6 flags readback", v, 6);
    wr(32, 0); wr(33, 800); wr(37, 480);
    rd(33, v); chk("R9 width 800", v, 800);
    rd(37, v); chk("R9 height 480", v, 480);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule